// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of external Ethernet PHYs over a two-wire serial management bus with 32-bit preamble frames. The bus side is a plain synchronous register port: a byte address, a write strobe with write data, and a read strobe that returns data one cycle later. Six word registers hold the clock divider and soft reset, the read command, the target PHY and register numbers, the data to write, the last data read, and the busy and not-valid flags.

A write to the data-to-write register starts a write frame at once. A read frame starts only when the read bit of the command register goes from 0 to 1. The line side drives a management clock (MDC) and the data pin through separate output, output-enable and input signals. The controller releases the data pin for the turnaround and data bits of a read, and samples the PHY's answer on the rising MDC edge. Software polls the flags until both are clear.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the flag register (byte 0x14) reads 0, the configuration register (byte 0x00) reads 7, MDC is low and the data pin output-enable is low.
- R2: The target register (byte 0x08) keeps the PHY number in bits 12:8 and the register number in bits 4:0, and every other bit reads 0.
- R3: Writing the data-to-write register (byte 0x0C) while idle sends, MSB first, 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10 and the 16 low write-data bits: 64 MDC cycles in all.
- R4: A 0-to-1 change of command bit 0 (byte 0x04) while idle sends a read frame with opcode 10. The output-enable is high for the first 46 bits and low for the 2 turnaround bits and the 16 data bits.
- R5: On a read, the PHY's data bit is sampled at each rising MDC edge of the data phase. After the frame, bits 15:0 of the result register (byte 0x10) hold those 16 bits, MSB first.
- R6: Flag bit 0 (busy) is 1 from the start of any frame to its end. Flag bit 2 (not-valid) is 1 from the start of a read until its result is stored. Not-valid never stays 1 while busy is 0.
- R7: Writing 1 to command bit 0 when it already holds 1 starts no frame. Software must write 0 first.
- R8: While busy, a write to the data-to-write register is dropped, and its readback keeps the old value. A rising read bit is also dropped. The frame in progress goes on unchanged.
- R9: Setting configuration bit 31 aborts any frame: busy and not-valid clear, and MDC and output-enable go low. No frame starts while the bit stays 1.
- R10: Configuration bits 2:0 hold a value n, and each MDC half period lasts 2^(n+1) clocks.
- R11: The data pin output changes only while MDC is low, so it is stable at every rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data appears on reg_rdata the next cycle |
| reg_rdata | output | 32 | Read data |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The assertions assume that the register port gives at most one access per cycle and that the reset input is held low for several cycles. The read-data input is only trusted during the data phase of a read. The bench keeps to this. Its tasks issue one strobe per clock, driven on the falling clock edge. The bench model of the PHY changes the data pin only after a falling MDC edge, so the value is settled before the controller samples it at the next rise.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int SEL_W      = 3;

  typedef enum logic [2:0] {
    W_CFG = 3'd0,
    W_CMD = 3'd1,
    W_ADR = 3'd2,
    W_CTL = 3'd3,
    W_STA = 3'd4,
    W_IND = 3'd5
  } word_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        rd,
    input logic [4:0]  phy,
    input logic [4:0]  rg,
    input logic [15:0] data
  );
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dd;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    dd = rd ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, ta, dd};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 2 ** SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last  = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(sel));
    tick  = run && (cnt_q == last);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        start,
  input  logic        is_read,
  input  logic [4:0]  phy,
  input  logic [4:0]  rg,
  input  logic [15:0] wdata,
  input  logic        tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic        rd_done
);
  logic                  busy_q, busy_d, mdc_q, mdc_d, rd_q, rd_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [15:0]           cap_q, cap_d;
  logic                  last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    busy_d  = busy_q;
    mdc_d   = mdc_q;
    rd_d    = rd_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    cap_d   = cap_q;
    rd_done = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
      mdc_d  = 1'b0;
      idx_d  = '0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      mdc_d  = 1'b0;
      idx_d  = '0;
      rd_d   = is_read;
      cap_d  = '0;
      sh_d   = build_frame(is_read, phy, rg, wdata);
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rd_q && idx_q >= IDX_W'(DATA_IDX)) cap_d = {cap_q[14:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        if (last_bit) begin
          busy_d  = 1'b0;
          rd_done = rd_q;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      mdc_q  <= mdc_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && idx_q >= IDX_W'(TA_IDX));
  assign rd_data = cap_q;

  // R11: pin value holds through the high half of MDC
  a_r11_pin_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> $stable(mdio_o));
  // R10: each divider tick during a frame flips MDC
  a_r10_tick_flips_mdc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && !clr) |=> (mdc_q != $past(mdc_q)));
  // R1: an idle engine keeps the line quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !mdio_oe));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic [2:0]       word;
  logic [SEL_W-1:0] div_q;
  logic             srst_q, cmd_q, nv_q;
  logic [4:0]       phy_q, rg_q;
  logic [15:0]      ctl_q, sta_q, rd_data;
  logic [31:0]      rdata_q, rmux;
  logic             busy, tick, rd_done, start_wr, start_rd, wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign word     = reg_addr[ADDR_W-1:2];
  assign wr_ok    = !busy && !srst_q;
  assign start_wr = reg_wr && word == W_CTL && wr_ok;
  assign start_rd = reg_wr && word == W_CMD && reg_wdata[0] && !cmd_q && wr_ok;

  always_comb begin
    rmux = '0;
    unique case (word)
      W_CFG:   rmux = {srst_q, 28'd0, div_q};
      W_CMD:   rmux = {31'd0, cmd_q};
      W_ADR:   rmux = {19'd0, phy_q, 3'd0, rg_q};
      W_CTL:   rmux = {16'd0, ctl_q};
      W_STA:   rmux = {16'd0, sta_q};
      W_IND:   rmux = {29'd0, nv_q, 1'b0, busy};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      div_q   <= 3'd7;
      srst_q  <= 1'b0;
      cmd_q   <= 1'b0;
      phy_q   <= '0;
      rg_q    <= '0;
      ctl_q   <= '0;
      sta_q   <= '0;
      nv_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_wr && word == W_CFG) begin
        div_q  <= reg_wdata[SEL_W-1:0];
        srst_q <= reg_wdata[31];
      end
      if (reg_wr && word == W_CMD) cmd_q <= reg_wdata[0];
      if (reg_wr && word == W_ADR) begin
        phy_q <= reg_wdata[12:8];
        rg_q  <= reg_wdata[4:0];
      end
      if (start_wr) ctl_q <= reg_wdata[15:0];
      if (srst_q)        nv_q <= 1'b0;
      else if (start_rd) nv_q <= 1'b1;
      else if (rd_done) begin
        nv_q  <= 1'b0;
        sta_q <= rd_data;
      end
      if (reg_rd) rdata_q <= rmux;
    end
  end

  assign reg_rdata = rdata_q;

  mdio_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_s_n), .run(busy), .sel(div_q), .tick(tick)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_s_n), .clr(srst_q), .start(start_wr || start_rd),
    .is_read(start_rd), .phy(phy_q), .rg(rg_q), .wdata(reg_wdata[15:0]),
    .tick(tick), .mdio_i(mdio_i), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_data(rd_data), .rd_done(rd_done)
  );

  // R6: not-valid only while a frame runs
  a_r6_nv_within_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    nv_q |-> busy);
  // R9: soft reset drops busy on the next edge
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    srst_q |=> !busy);
  // R8: a data write during a frame leaves the register alone
  a_r8_ctl_kept: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && reg_wr && word == W_CTL) |=> $stable(ctl_q));
  // R7: a held read bit starts nothing
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && reg_wr && word == W_CMD && cmd_q) |=> !busy);
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0;
  int checks = 0;

  logic [63:0] mon_bits = '0;
  logic [63:0] mon_oe = '0;
  int          mon_cnt = 0;
  time         t_prev = 0;
  time         t_last = 0;
  logic [63:0] phy_resp = '0;
  int          hold_bad = 0;
  logic        mdc_prev = 1'b0;
  logic        pin_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    mon_bits = {mon_bits[62:0], mdio_oe ? mdio_o : 1'b0};
    mon_oe   = {mon_oe[62:0], mdio_oe};
    mon_cnt  = mon_cnt + 1;
    t_prev   = t_last;
    t_last   = $time;
  end

  always @(negedge mdc) begin
    if ((mon_cnt % 64) != 0) mdio_i <= phy_resp[63 - (mon_cnt % 64)];
  end

  always @(negedge clk) begin
    if (mdc && mdc_prev && mdio_oe && mdio_o != pin_prev) hold_bad = hold_bad + 1;
    mdc_prev = mdc;
    pin_prev = mdio_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      bus_read(5'h14, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    bus_read(5'h14, v); check("R1 flags", v, 0);
    bus_read(5'h00, v); check("R1 config", v, 7);
    check("R1 mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, v); check("R2 field mask", v, 32'h0000_1F1F);
    bus_write(5'h08, 32'h0000_0A13);
    bus_read(5'h08, v); check("R2 readback", v, 32'h0000_0A13);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int base;
    bus_write(5'h00, 0);
    bus_write(5'h08, {19'd0, 5'd5, 3'd0, 5'h1A});
    base = mon_cnt;
    bus_write(5'h0C, 32'h0000_A5C3);
    bus_read(5'h14, v); check("R6 busy during write", v, 1);
    wait_idle();
    check("R3 bit count", mon_cnt - base, 64);
    check("R3 frame", mon_bits, wr_frame(5'd5, 5'h1A, 16'hA5C3));
    bus_read(5'h14, v); check("R6 idle after write", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    bus_write(5'h08, {19'd0, 5'd9, 3'd0, 5'h02});
    phy_resp = {48'd0, 16'h3C96};
    bus_write(5'h04, 0);
    bus_write(5'h04, 1);
    bus_read(5'h14, v); check("R6 busy+notvalid", v, 5);
    wait_idle();
    check("R4 read frame", mon_bits, {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd9, 5'h02, 18'd0});
    check("R4 release", mon_oe, {{46{1'b1}}, 18'd0});
    bus_read(5'h10, v); check("R5 result", v, 32'h0000_3C96);
    bus_read(5'h14, v); check("R6 flags after read", v, 0);
  endtask

  task automatic t_cmd_hold();
    logic [31:0] v;
    int base;
    base = mon_cnt;
    bus_write(5'h04, 1);
    repeat (20) @(negedge clk);
    bus_read(5'h14, v); check("R7 held bit flags", v, 0);
    check("R7 held bit line", mon_cnt - base, 0);
    phy_resp = {48'd0, 16'h5A01};
    bus_write(5'h04, 0);
    bus_write(5'h04, 1);
    bus_read(5'h14, v); check("R7 rearmed", v, 5);
    wait_idle();
    bus_read(5'h10, v); check("R5 second result", v, 32'h0000_5A01);
    bus_write(5'h04, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int base;
    bus_write(5'h08, {19'd0, 5'd3, 3'd0, 5'h07});
    base = mon_cnt;
    bus_write(5'h0C, 32'h0000_1111);
    bus_write(5'h0C, 32'h0000_2222);
    bus_write(5'h04, 1);
    bus_read(5'h0C, v); check("R8 data kept", v, 32'h0000_1111);
    bus_read(5'h14, v); check("R8 no notvalid", v, 1);
    wait_idle();
    check("R8 frame intact", mon_bits, wr_frame(5'd3, 5'h07, 16'h1111));
    check("R8 one frame", mon_cnt - base, 64);
    bus_write(5'h04, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    bus_write(5'h0C, 32'h0000_BEEF);
    repeat (30) @(negedge clk);
    bus_write(5'h00, 32'h8000_0000);
    repeat (3) @(negedge clk);
    bus_read(5'h14, v); check("R9 busy cleared", v, 0);
    check("R9 line low", {mdc, mdio_oe}, 0);
    bus_write(5'h0C, 32'h0000_0001);
    bus_read(5'h14, v); check("R9 held off", v, 0);
    bus_write(5'h00, 0);
  endtask

  task automatic t_div(input logic [2:0] n);
    bus_write(5'h00, {29'd0, n});
    bus_write(5'h0C, 32'h0000_0F0F);
    wait_idle();
    check("R10 MDC period", (t_last - t_prev) / CLK_PERIOD, 64'(4 << n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_write();
    t_read();
    t_cmd_hold();
    t_busy_ignore();
    t_soft_reset();
    t_div(3'd0);
    t_div(3'd1);
    t_div(3'd2);
    check("R11 pin stable while MDC high", 64'(hold_bad), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule